// File: doc/BRIEF.md
# System-Control Coprocessor Register File

This block answers register-transfer requests aimed at the system-control coprocessor of a small CPU that uses a protection unit instead of a paging MMU. A request names a coprocessor number, a primary register index, a secondary register field and an op2 selector. Reads return either a fixed identification word or the contents of a writable register. Writes update the control register or one of two tightly-coupled-memory (TCM) region registers. One region register is for data and one is for instructions.

From the control register and the two region registers, the block derives an enable, a base, a size and an end address for each TCM region. An address router uses these values to steer accesses. All of them are combinational functions of the stored registers. Software can therefore move or resize a region at run time, and the new window is in force from the cycle after the write.

Protection-region, cacheability, bufferability and cache-maintenance registers accept writes and discard them. Requests to any other coprocessor are ignored.

Top module: `cp_cfg_regfile`

## Requirements
- R1: After reset the control register reads 0x00000078 and both region registers read 0.
- R2: A read of coprocessor 15, primary 0, op2=0 returns 0x41059461. A read of primary 0, op2=1 returns 0x0f0d2112.
- R3: A write to coprocessor 15, primary 1 (any secondary field, any op2) loads the control register. A read of primary 1 returns the last value written.
- R4: The data region register sits at coprocessor 15, primary 9, secondary 1, op2=0. The instruction region register sits at the same location with op2=1. Both read back what was last written.
- R5: When control bit 16 is set, the data region is enabled. Its base is the data region register with bits [11:0] cleared. Its size is 512 shifted left by bits [5:1] of that register, truncated to 32 bits. Its end is base plus size, modulo 2^32.
- R6: When control bit 18 is set, the instruction region is enabled. Its base is always 0, and its size and end follow the formula of R5 applied to the instruction region register.
- R7: A disabled region reports enable 0, base 0xFFFFFFFF, size 0 and end 0.
- R8: Writes to primary registers 2, 3, 5, 6 and 7 change no readable register and no region output.
- R9: Requests whose coprocessor number is not 15 read as 0 and change no register.
- R10: A read of any other combination of primary, secondary and op2 returns 0. A cycle with no read request drives read data to 0.
- R11: Region outputs take new values in the first cycle after the clock edge that captures a write to the control register or to a region register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| cpNum | input | 4 | Target coprocessor number |
| priReg | input | 4 | Primary register index |
| secReg | input | 4 | Secondary register field |
| opSel | input | 3 | op2 selector |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data (same cycle as the read request) |
| dtcmEn | output | 1 | Data region enabled |
| dtcmBase | output | 32 | Data region base |
| dtcmSize | output | 32 | Data region size in bytes |
| dtcmEnd | output | 32 | Data region end (base + size) |
| itcmEn | output | 1 | Instruction region enabled |
| itcmBase | output | 32 | Instruction region base |
| itcmSize | output | 32 | Instruction region size in bytes |
| itcmEnd | output | 32 | Instruction region end (base + size) |

## Verification
Read data is combinational from the request fields and the stored registers. The bench therefore samples rdData one nanosecond after it drives a read, inside the same cycle. A write is captured at the next rising edge, and the region outputs follow with no further register. The bench drives every request on a falling edge, advances its behavioural model on the rising edge, and compares all eight region outputs against that model on each falling edge. Readback checks that follow a write are issued no earlier than the cycle after the capturing edge.

// File: rtl/cp_cfg_pkg.sv
package cp_cfg_pkg;
  typedef enum logic [2:0] {
    RD_ZERO, RD_CHIP, RD_CACHE, RD_CTRL, RD_DTCM, RD_ITCM
  } rdSel_e;

  typedef struct packed {
    logic   ctrlWe;
    logic   dtcmWe;
    logic   itcmWe;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/cp_cfg_ctrl.sv
module cp_cfg_ctrl
  import cp_cfg_pkg::*;
#(
  parameter int CP_W     = 4,
  parameter int REG_W    = 4,
  parameter int OP_W     = 3,
  parameter int CP_SELF  = 15,
  parameter int PRI_ID   = 0,
  parameter int PRI_CTRL = 1,
  parameter int PRI_TCM  = 9,
  parameter int SEC_TCM  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [CP_W-1:0]  cpNum,
  input  logic [REG_W-1:0] priReg,
  input  logic [REG_W-1:0] secReg,
  input  logic [OP_W-1:0]  opSel,
  output strobe_t          strb
);
  logic selfHit;
  logic tcmSlot;

  assign selfHit = reqValid && (cpNum == CP_W'(CP_SELF));
  assign tcmSlot = (priReg == REG_W'(PRI_TCM)) && (secReg == REG_W'(SEC_TCM));

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_ZERO;
    if (selfHit) begin
      if (reqWrite) begin
        if (priReg == REG_W'(PRI_CTRL)) strb.ctrlWe = 1'b1;
        if (tcmSlot && opSel == OP_W'(0)) strb.dtcmWe = 1'b1;
        if (tcmSlot && opSel == OP_W'(1)) strb.itcmWe = 1'b1;
      end else begin
        if (priReg == REG_W'(PRI_ID) && opSel == OP_W'(0)) strb.rdSel = RD_CHIP;
        else if (priReg == REG_W'(PRI_ID) && opSel == OP_W'(1)) strb.rdSel = RD_CACHE;
        else if (priReg == REG_W'(PRI_CTRL)) strb.rdSel = RD_CTRL;
        else if (tcmSlot && opSel == OP_W'(0)) strb.rdSel = RD_DTCM;
        else if (tcmSlot && opSel == OP_W'(1)) strb.rdSel = RD_ITCM;
      end
    end
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ctrlWe, strb.dtcmWe, strb.itcmWe})); // R4
  AST_FOREIGN_CP_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cpNum != CP_W'(CP_SELF)) |->
      (!strb.ctrlWe && !strb.dtcmWe && !strb.itcmWe && strb.rdSel == RD_ZERO)); // R9
endmodule

// File: rtl/cp_cfg_region.sv
module cp_cfg_region #(
  parameter int DATA_W     = 32,
  parameter int SIZE_UNIT  = 512,
  parameter int ALIGN_BITS = 12,
  parameter int FIELD_LSB  = 1,
  parameter int FIELD_W    = 5,
  parameter bit FIXED_BASE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DATA_W-1:0] regVal,
  output logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] size,
  output logic [DATA_W-1:0] endAddr
);
  logic [DATA_W-1:0]  rawBase;
  logic [FIELD_W-1:0] sizeCode;

  assign sizeCode = regVal[FIELD_LSB +: FIELD_W];

  generate
    if (FIXED_BASE) begin : g_fixed
      assign rawBase = '0;
    end else begin : g_movable
      assign rawBase = {regVal[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end
  endgenerate

  always_comb begin
    if (enable) begin
      base    = rawBase;
      size    = DATA_W'(SIZE_UNIT) << sizeCode;
      endAddr = rawBase + (DATA_W'(SIZE_UNIT) << sizeCode);
    end else begin
      base    = '1;
      size    = '0;
      endAddr = '0;
    end
  end

  AST_SIZE_POWER_OF_TWO: assert property (@(posedge clk) disable iff (!rstN)
    $countones(size) <= 1); // R5
  AST_END_FOLLOWS_BASE: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (endAddr - base == size)); // R5
endmodule

// File: rtl/cp_cfg_datapath.sv
module cp_cfg_datapath
  import cp_cfg_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter logic [31:0] CTRL_RESET  = 32'h0000_0078,
  parameter logic [31:0] CHIP_ID     = 32'h4105_9461,
  parameter logic [31:0] CACHE_ID    = 32'h0f0d_2112,
  parameter int          DTCM_EN_BIT = 16,
  parameter int          ITCM_EN_BIT = 18,
  parameter int          SIZE_UNIT   = 512,
  parameter int          ALIGN_BITS  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        regionEn,
  output logic [DATA_W-1:0] regionBase [2],
  output logic [DATA_W-1:0] regionSize [2],
  output logic [DATA_W-1:0] regionEnd  [2]
);
  logic [DATA_W-1:0] ctrlQ;
  logic [DATA_W-1:0] dtcmQ;
  logic [DATA_W-1:0] itcmQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= DATA_W'(CTRL_RESET);
      dtcmQ <= '0;
      itcmQ <= '0;
    end else begin
      if (strb.ctrlWe) ctrlQ <= wrData;
      if (strb.dtcmWe) dtcmQ <= wrData;
      if (strb.itcmWe) itcmQ <= wrData;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_CHIP:  rdData = DATA_W'(CHIP_ID);
      RD_CACHE: rdData = DATA_W'(CACHE_ID);
      RD_CTRL:  rdData = ctrlQ;
      RD_DTCM:  rdData = dtcmQ;
      RD_ITCM:  rdData = itcmQ;
      default:  rdData = '0;
    endcase
  end

  assign regionEn[0] = ctrlQ[DTCM_EN_BIT];
  assign regionEn[1] = ctrlQ[ITCM_EN_BIT];

  for (genvar g = 0; g < 2; g++) begin : g_region
    cp_cfg_region #(
      .DATA_W    (DATA_W),
      .SIZE_UNIT (SIZE_UNIT),
      .ALIGN_BITS(ALIGN_BITS),
      .FIELD_LSB (1),
      .FIELD_W   (5),
      .FIXED_BASE(g == 1)
    ) u_region (
      .clk    (clk),
      .rstN   (rstN),
      .enable (regionEn[g]),
      .regVal ((g == 0) ? dtcmQ : itcmQ),
      .base   (regionBase[g]),
      .size   (regionSize[g]),
      .endAddr(regionEnd[g])
    );
  end

  AST_CTRL_LOADS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWe |=> (ctrlQ == $past(wrData))); // R3
  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ctrlWe |=> $stable(ctrlQ)); // R8
  AST_DTCM_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.dtcmWe |=> $stable(dtcmQ)); // R8
  AST_ITCM_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.itcmWe |=> $stable(itcmQ)); // R8
endmodule

// File: rtl/cp_cfg_regfile.sv
module cp_cfg_regfile
  import cp_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [3:0]  cpNum,
  input  logic [3:0]  priReg,
  input  logic [3:0]  secReg,
  input  logic [2:0]  opSel,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        dtcmEn,
  output logic [31:0] dtcmBase,
  output logic [31:0] dtcmSize,
  output logic [31:0] dtcmEnd,
  output logic        itcmEn,
  output logic [31:0] itcmBase,
  output logic [31:0] itcmSize,
  output logic [31:0] itcmEnd
);
  strobe_t     strb;
  logic [1:0]  regionEn;
  logic [31:0] regionBase [2];
  logic [31:0] regionSize [2];
  logic [31:0] regionEnd  [2];

  cp_cfg_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .cpNum   (cpNum),
    .priReg  (priReg),
    .secReg  (secReg),
    .opSel   (opSel),
    .strb    (strb)
  );

  cp_cfg_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .rdData    (rdData),
    .regionEn  (regionEn),
    .regionBase(regionBase),
    .regionSize(regionSize),
    .regionEnd (regionEnd)
  );

  assign dtcmEn   = regionEn[0];
  assign dtcmBase = regionBase[0];
  assign dtcmSize = regionSize[0];
  assign dtcmEnd  = regionEnd[0];
  assign itcmEn   = regionEn[1];
  assign itcmBase = regionBase[1];
  assign itcmSize = regionSize[1];
  assign itcmEnd  = regionEnd[1];

  AST_DISABLED_DTCM_SENTINEL: assert property (@(posedge clk) disable iff (!rstN)
    !dtcmEn |-> (dtcmBase == 32'hFFFF_FFFF && dtcmSize == 0 && dtcmEnd == 0)); // R7
  AST_DISABLED_ITCM_SENTINEL: assert property (@(posedge clk) disable iff (!rstN)
    !itcmEn |-> (itcmBase == 32'hFFFF_FFFF && itcmSize == 0 && itcmEnd == 0)); // R7
  AST_ITCM_BASE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    itcmEn |-> (itcmBase == 32'h0)); // R6
  AST_NO_READ_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || reqWrite) |-> (rdData == 32'h0)); // R10
endmodule

// File: tb/cp_cfg_regfile_bench.sv
`timescale 1ns/1ps
module cp_cfg_regfile_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [3:0] cpNum = '0, priReg = '0, secReg = '0;
  logic [2:0] opSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, dtcmBase, dtcmSize, dtcmEnd, itcmBase, itcmSize, itcmEnd;
  logic dtcmEn, itcmEn;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // behavioural model state
  logic [31:0] mCtrl, mDtcm, mItcm;

  always #4 clk = ~clk;

  cp_cfg_regfile u_cp_cfg_regfile (.*);

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 32'h78; mDtcm = 0; mItcm = 0;
    end else if (reqValid && reqWrite && cpNum == 4'd15) begin
      if (priReg == 4'd1) mCtrl = wrData;
      else if (priReg == 4'd9 && secReg == 4'd1 && opSel == 3'd0) mDtcm = wrData;
      else if (priReg == 4'd9 && secReg == 4'd1 && opSel == 3'd1) mItcm = wrData;
    end
  end

  function automatic logic [31:0] expBase(bit en, logic [31:0] r, bit fixedZero);
    if (!en) return 32'hFFFF_FFFF;
    return fixedZero ? 32'h0 : (r & 32'hFFFF_F000);
  endfunction
  function automatic logic [31:0] expSize(bit en, logic [31:0] r);
    logic [31:0] s;
    s = 32'd512 << r[5:1];
    return en ? s : 32'h0;
  endfunction
  function automatic logic [31:0] expEnd(bit en, logic [31:0] r, bit fixedZero);
    return en ? expBase(en, r, fixedZero) + expSize(en, r) : 32'h0;
  endfunction
  function automatic logic [31:0] expRead(logic [3:0] cp, logic [3:0] p, logic [3:0] s, logic [2:0] o);
    if (cp != 4'd15) return 0;
    if (p == 0 && o == 0) return 32'h4105_9461;
    if (p == 0 && o == 1) return 32'h0f0d_2112;
    if (p == 1) return mCtrl;
    if (p == 9 && s == 1 && o == 0) return mDtcm;
    if (p == 9 && s == 1 && o == 1) return mItcm;
    return 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkRegions(string tag);
    chk({tag, " dtcmEn"},   {31'b0, dtcmEn}, {31'b0, mCtrl[16]});
    chk({tag, " dtcmBase"}, dtcmBase, expBase(mCtrl[16], mDtcm, 1'b0));
    chk({tag, " dtcmSize"}, dtcmSize, expSize(mCtrl[16], mDtcm));
    chk({tag, " dtcmEnd"},  dtcmEnd,  expEnd(mCtrl[16], mDtcm, 1'b0));
    chk({tag, " itcmEn"},   {31'b0, itcmEn}, {31'b0, mCtrl[18]});
    chk({tag, " itcmBase"}, itcmBase, expBase(mCtrl[18], mItcm, 1'b1));
    chk({tag, " itcmSize"}, itcmSize, expSize(mCtrl[18], mItcm));
    chk({tag, " itcmEnd"},  itcmEnd,  expEnd(mCtrl[18], mItcm, 1'b1));
  endtask

  // R11: region outputs compared against the model on every falling edge
  always @(negedge clk) if (rstN && !finished) checkRegions("R11 per-cycle");

  task automatic doWrite(logic [3:0] cp, logic [3:0] p, logic [3:0] s, logic [2:0] o, logic [31:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; cpNum = cp; priReg = p; secReg = s; opSel = o; wrData = d;
    @(negedge clk);
    reqValid = 0; reqWrite = 0; wrData = 0;
  endtask

  task automatic doRead(string tag, logic [3:0] cp, logic [3:0] p, logic [3:0] s, logic [2:0] o,
                        logic [31:0] exp);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; cpNum = cp; priReg = p; secReg = s; opSel = o;
    #1;
    chk({tag, " model"}, rdData, expRead(cp, p, s, o));
    chk({tag, " literal"}, rdData, exp);
    @(negedge clk);
    reqValid = 0;
    #1;
    chk("R10 idle read data", rdData, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state, R7 disabled outputs
    checkRegions("R7 after reset");
    doRead("R1 ctrl reset", 15, 1, 0, 0, 32'h78);
    doRead("R1 dtcm reset", 15, 9, 1, 0, 0);
    doRead("R1 itcm reset", 15, 9, 1, 1, 0);
    // R2 identification words
    doRead("R2 chip id",  15, 0, 0, 0, 32'h4105_9461);
    doRead("R2 cache id", 15, 0, 0, 1, 32'h0f0d_2112);
    // R10 undefined combinations
    doRead("R10 pri0 op2", 15, 0, 0, 2, 0);
    doRead("R10 pri4",     15, 4, 0, 0, 0);
    doRead("R10 pri9 op2", 15, 9, 1, 2, 0);
    doRead("R10 pri9 sec0", 15, 9, 0, 0, 0);
    // R4 region register access while regions disabled
    doWrite(15, 9, 1, 0, 32'h0080_000A);
    doWrite(15, 9, 1, 1, 32'h0000_0010);
    doRead("R4 dtcm readback", 15, 9, 1, 0, 32'h0080_000A);
    doRead("R4 itcm readback", 15, 9, 1, 1, 32'h0000_0010);
    checkRegions("R7 still disabled");
    chk("R7 dtcm base sentinel", dtcmBase, 32'hFFFF_FFFF);
    // R3, R5, R11 enable data region
    doWrite(15, 1, 3, 5, 32'h0001_0078);
    doRead("R3 ctrl readback", 15, 1, 0, 0, 32'h0001_0078);
    chk("R5 dtcm base", dtcmBase, 32'h0080_0000);
    chk("R5 dtcm size", dtcmSize, 32'h0000_4000);
    chk("R5 dtcm end",  dtcmEnd,  32'h0080_4000);
    // R6 enable instruction region
    doWrite(15, 1, 0, 0, 32'h0005_0078);
    chk("R6 itcm base", itcmBase, 32'h0);
    chk("R6 itcm size", itcmSize, 32'h0002_0000);
    chk("R6 itcm end",  itcmEnd,  32'h0002_0000);
    // R11 move the data region at run time
    doWrite(15, 9, 1, 0, 32'h02FF_F01E);
    chk("R11 moved base", dtcmBase, 32'h02FF_F000);
    chk("R11 moved size", dtcmSize, 32'h0100_0000);
    chk("R11 moved end",  dtcmEnd,  32'h03FF_F000);
    // R5 size truncation at the largest shift
    doWrite(15, 9, 1, 0, 32'hFFFF_F03E);
    chk("R5 truncated size", dtcmSize, 32'h0);
    chk("R5 truncated end",  dtcmEnd,  32'hFFFF_F000);
    // R8 discarded writes
    for (int p = 2; p <= 7; p++) begin
      if (p != 4) doWrite(15, 4'(p), 1, 0, 32'hFFFF_FFFF);
    end
    doWrite(15, 9, 0, 0, 32'h1234_5678);
    doRead("R8 ctrl kept", 15, 1, 0, 0, 32'h0005_0078);
    doRead("R8 dtcm kept", 15, 9, 1, 0, 32'hFFFF_F03E);
    doRead("R8 itcm kept", 15, 9, 1, 1, 32'h0000_0010);
    checkRegions("R8 outputs kept");
    // R9 foreign coprocessor
    doWrite(14, 1, 0, 0, 32'h0);
    doWrite(0, 9, 1, 0, 32'h0);
    doRead("R9 foreign read id", 14, 0, 0, 0, 0);
    doRead("R9 foreign read ctrl", 0, 1, 0, 0, 0);
    doRead("R9 ctrl unchanged", 15, 1, 0, 0, 32'h0005_0078);
    chk("R9 dtcm still enabled", {31'b0, dtcmEn}, 32'd1);
    // R7 disable both regions again
    doWrite(15, 1, 0, 0, 32'h0000_0078);
    chk("R7 dtcm base", dtcmBase, 32'hFFFF_FFFF);
    chk("R7 itcm base", itcmBase, 32'hFFFF_FFFF);
    chk("R7 itcm size", itcmSize, 32'h0);
    chk("R7 itcm end",  itcmEnd,  32'h0);
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule